// File: doc/BRIEF.md
# Row disturbance test sequencer

This block runs a complete disturbance (row-hammer) experiment against one DRAM bank through an abstract command port. A test begins with a one-cycle `start`. The block captures the configuration and writes the data pattern into every row of the bank. It then activates aggressor rows over and over, reads them and precharges them, and inserts refresh commands at a programmable interval. Last, it reads the bank back and reports every word that no longer matches the pattern. Each report is a row, a column, a mask of the flipped bits and the direction of the flip.

There are two test modes. In sweep mode every row of the bank becomes the aggressor in turn, and afterwards the whole bank is checked. In targeted mode one aggressor row, or an alternating pair of rows, is hammered, and every row except the aggressors is checked. An open-row option holds one activation open and reads it repeatedly. This is the non-disturbing case that the activate-per-access loop is compared against. Electrical timing, address scrambling and the device itself lie outside the block. Commands leave through a valid/ready handshake, and read data returns through `rd_valid` and `rd_data`.

Top module: `disturb_test_seq`

## Requirements
- R1: A command is presented on `cmd_valid` with `cmd_op`, `cmd_row`, `cmd_col`, `cmd_wdata` and `cmd_bank`. These stay unchanged until the cycle in which `cmd_ready` is high. The encodings are 1 activate, 2 read, 3 write, 4 precharge and 5 refresh.
- R2: After `start`, rows 0 to ROWS-1 are filled in ascending order. Each row gets one activate, then one write per column in ascending column order carrying the configured pattern, then one precharge. That is ROWS*COLS writes in total.
- R3: With the open-row option off, each hammer iteration is an activate, a read and a precharge of the same aggressor row, and no activate is issued while a row is open. Exactly `hammer_n` iterations are issued for each aggressor. When `hammer_n` is 0 the hammer phase is skipped.
- R4: In targeted mode with `dual_en` set, the iterations alternate between `agg_a` and `agg_b`, starting with `agg_a`. As a result `agg_a` receives ceil(N/2) activations and `agg_b` receives floor(N/2).
- R5: With the open-row option on, each aggressor receives one activate, then `hammer_n` reads, then one precharge. `dual_en` has no effect in this mode.
- R6: Two accepted activate commands are never fewer than `act_gap` cycles apart.
- R7: A `ref_period` of 0 produces no refresh. A nonzero value produces refresh commands during the hammer phase, and each one is issued only while no row is open.
- R8: In sweep mode, rows 0 to ROWS-1 are each the aggressor in turn. With `dual_en` set, the partner of row r is r+1. The partner of the last row is clamped to ROWS-2.
- R9: Readback visits the rows in ascending order: one activate, then one read per column, each of which waits for `rd_valid`, then one precharge. In targeted mode the aggressor rows are skipped entirely. That means `agg_a`, plus `agg_b` when dual mode applies.
- R10: A word that mismatches produces a 1-to-0 record first, if any bits fell: `err_dir`=1 and mask = pattern & ~data. It then produces a 0-to-1 record, if any bits rose: `err_dir`=0 and mask = ~pattern & data. Records follow readback order and are held until `err_ready`.
- R11: `err_total` clears at `start`, counts every accepted record and saturates at its maximum value.
- R12: After reset the block is idle, with `busy`, `done`, `cmd_valid`, `err_valid` low and `err_total` at 0. `done` pulses once when a test ends. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test (captured when idle) |
| mode_sweep | input | 1 | 1: sweep every row; 0: targeted aggressors |
| dual_en | input | 1 | Alternate two aggressor rows |
| open_row | input | 1 | Keep one activation open and read repeatedly |
| test_bank | input | BANK_W | Bank under test |
| agg_a | input | RW | First aggressor row (targeted mode) |
| agg_b | input | RW | Second aggressor row (targeted dual mode) |
| pattern | input | DW | Data pattern written and expected |
| hammer_n | input | 32 | Hammer iterations per aggressor |
| act_gap | input | TW | Minimum cycles between activates |
| ref_period | input | TW | Hammer cycles between refreshes, 0 disables |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_op | output | 3 | Command code |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | RW | Command row |
| cmd_col | output | CW | Command column |
| cmd_wdata | output | DW | Write data |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | DW | Read data |
| err_valid | output | 1 | Mismatch record valid |
| err_ready | input | 1 | Mismatch record accepted |
| err_row | output | RW | Mismatching row |
| err_col | output | CW | Mismatching column |
| err_mask | output | DW | Flipped bits of this direction |
| err_dir | output | 1 | 1: bits fell 1 to 0; 0: bits rose 0 to 1 |
| err_total | output | ERR_W | Saturating count of records |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle pulse at test end |

## Verification
The checker watches every cycle for the following:
- payload holding on both handshakes;
- the spacing between accepted activates;
- no second activate and no refresh while a row is open;
- precharge naming the open row;
- the step and saturation of the error count.

Other properties can only be shown at the end of whole scenarios, against a bench memory model that flips bits in the neighbours of heavily activated rows. These are the per-row activation and read totals that prove the alternation and sweep orders and the clamp at the last row, the skipping of aggressor rows, the quiet open-row case, and the exact order and content of the mismatch records.

// File: rtl/dts_pkg.sv
package dts_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_REF = 3'd5
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_FACT, S_FWR, S_FPRE,
        S_HREF, S_HACT, S_HRD, S_HPRE,
        S_RNEXT, S_RACT, S_RRD, S_RWAIT,
        S_RDOWN, S_RUP, S_RPRE, S_DONE
    } st_e;

endpackage

// File: rtl/dts_act_spacer.sv
// Counts cycles since the last accepted activate and permits the next one
// once the programmed spacing has elapsed.
module dts_act_spacer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_fire,
    input  logic [TW-1:0] gap_min,
    output logic          act_ok
);
    logic [TW-1:0] since_d, since_q;

    always_comb begin
        since_d = since_q;
        if (act_fire)
            since_d = TW'(1);
        else if (since_q != '1)
            since_d = since_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_q <= '1;
        else        since_q <= since_d;
    end

    assign act_ok = (since_q >= gap_min);
endmodule

// File: rtl/dts_ref_timer.sv
// Counts hammer-phase cycles and raises a pending refresh each period.
module dts_ref_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          taken,
    input  logic [TW-1:0] period,
    output logic          pending
);
    logic [TW-1:0] cnt_d, cnt_q;
    logic          pend_d, pend_q;

    always_comb begin
        cnt_d  = cnt_q;
        pend_d = pend_q;
        if (clear) begin
            cnt_d  = '0;
            pend_d = 1'b0;
        end else begin
            if (taken) pend_d = 1'b0;
            if (run && period != '0) begin
                if (cnt_q >= period - TW'(1)) begin
                    cnt_d  = '0;
                    pend_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + TW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/dts_flip_cmp.sv
// Splits a readback mismatch into fallen and risen bit masks.
module dts_flip_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] expect_w,
    input  logic [DW-1:0] data_w,
    output logic [DW-1:0] down_m,
    output logic [DW-1:0] up_m
);
    assign down_m = expect_w & ~data_w;
    assign up_m   = ~expect_w & data_w;
endmodule

// File: rtl/disturb_test_seq.sv
module disturb_test_seq
    import dts_pkg::*;
#(
    parameter int ROWS   = 16,
    parameter int COLS   = 4,
    parameter int DW     = 8,
    parameter int BANK_W = 3,
    parameter int TW     = 8,
    parameter int ERR_W  = 16,
    localparam int RW    = $clog2(ROWS),
    localparam int CW    = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_sweep,
    input  logic              dual_en,
    input  logic              open_row,
    input  logic [BANK_W-1:0] test_bank,
    input  logic [RW-1:0]     agg_a,
    input  logic [RW-1:0]     agg_b,
    input  logic [DW-1:0]     pattern,
    input  logic [31:0]       hammer_n,
    input  logic [TW-1:0]     act_gap,
    input  logic [TW-1:0]     ref_period,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [RW-1:0]     cmd_row,
    output logic [CW-1:0]     cmd_col,
    output logic [DW-1:0]     cmd_wdata,
    input  logic              rd_valid,
    input  logic [DW-1:0]     rd_data,
    output logic              err_valid,
    input  logic              err_ready,
    output logic [RW-1:0]     err_row,
    output logic [CW-1:0]     err_col,
    output logic [DW-1:0]     err_mask,
    output logic              err_dir,
    output logic [ERR_W-1:0]  err_total,
    output logic              busy,
    output logic              done
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    typedef struct packed {
        st_e               st;
        logic [BANK_W-1:0] bank;
        logic              sweep;
        logic              dual;
        logic              open;
        logic [RW-1:0]     agg_a;
        logic [RW-1:0]     agg_b;
        logic [DW-1:0]     pat;
        logic [31:0]       n;
        logic [TW-1:0]     gap;
        logic [TW-1:0]     per;
        logic [RW-1:0]     row;
        logic [RW-1:0]     base;
        logic [CW-1:0]     col;
        logic              sel_b;
        logic [31:0]       iter;
        logic [DW-1:0]     rdat;
        logic [ERR_W-1:0]  total;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    logic          hs, ehs, act_ok, ref_pend, dual_live;
    logic          hammer_run, excluded;
    logic [RW-1:0] partner, hrow;
    logic [DW-1:0] cmp_data, down_m, up_m;
    op_e           op;

    assign hs         = cmd_valid && cmd_ready;
    assign ehs        = err_valid && err_ready;
    assign dual_live  = s_q.dual && !s_q.open;
    assign hammer_run = (s_q.st == S_HACT) || (s_q.st == S_HRD) ||
                        (s_q.st == S_HPRE) || (s_q.st == S_HREF);

    // Partner row: sweep uses the upper neighbour, clamped at the last row.
    always_comb begin
        if (s_q.sweep)
            partner = (s_q.base == LAST_ROW) ? s_q.base - RW'(1) : s_q.base + RW'(1);
        else
            partner = s_q.agg_b;
    end

    assign hrow     = (dual_live && s_q.sel_b) ? partner :
                      (s_q.sweep ? s_q.base : s_q.agg_a);
    assign excluded = !s_q.sweep &&
                      ((s_q.row == s_q.agg_a) || (dual_live && s_q.row == s_q.agg_b));
    assign cmp_data = (s_q.st == S_RWAIT) ? rd_data : s_q.rdat;

    dts_act_spacer #(.TW(TW)) spacer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_fire(hs && op == OP_ACT),
        .gap_min (s_q.gap),
        .act_ok  (act_ok)
    );

    dts_ref_timer #(.TW(TW)) reftim_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (s_q.st == S_IDLE),
        .run    (hammer_run),
        .taken  (hs && op == OP_REF),
        .period (s_q.per),
        .pending(ref_pend)
    );

    dts_flip_cmp #(.DW(DW)) cmp_i (
        .expect_w(s_q.pat),
        .data_w  (cmp_data),
        .down_m  (down_m),
        .up_m    (up_m)
    );

    // Command and report outputs decoded from the registered state.
    always_comb begin
        op        = OP_NOP;
        cmd_valid = 1'b0;
        cmd_row   = s_q.row;
        cmd_col   = '0;
        unique case (s_q.st)
            S_FACT, S_RACT: begin op = OP_ACT; cmd_valid = act_ok; end
            S_HACT:         begin op = OP_ACT; cmd_valid = act_ok; cmd_row = hrow; end
            S_FWR:          begin op = OP_WR;  cmd_valid = 1'b1; cmd_col = s_q.col; end
            S_RRD:          begin op = OP_RD;  cmd_valid = 1'b1; cmd_col = s_q.col; end
            S_HRD:          begin op = OP_RD;  cmd_valid = 1'b1; cmd_row = hrow; end
            S_FPRE, S_RPRE: begin op = OP_PRE; cmd_valid = 1'b1; end
            S_HPRE:         begin op = OP_PRE; cmd_valid = 1'b1; cmd_row = hrow; end
            S_HREF:         begin op = OP_REF; cmd_valid = 1'b1; cmd_row = '0; end
            default:        ;
        endcase
    end

    assign cmd_op    = op;
    assign cmd_bank  = s_q.bank;
    assign cmd_wdata = s_q.pat;
    assign err_valid = (s_q.st == S_RDOWN) || (s_q.st == S_RUP);
    assign err_dir   = (s_q.st == S_RDOWN);
    assign err_mask  = (s_q.st == S_RDOWN) ? down_m : up_m;
    assign err_row   = s_q.row;
    assign err_col   = s_q.col;
    assign err_total = s_q.total;
    assign busy      = (s_q.st != S_IDLE);
    assign done      = s_q.done;

    // Next-state computation.
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (ehs && s_q.total != '1)
            s_d.total = s_q.total + ERR_W'(1);

        unique case (s_q.st)
            S_IDLE: if (start) begin
                s_d.st    = S_FACT;
                s_d.bank  = test_bank;
                s_d.sweep = mode_sweep;
                s_d.dual  = dual_en;
                s_d.open  = open_row;
                s_d.agg_a = agg_a;
                s_d.agg_b = agg_b;
                s_d.pat   = pattern;
                s_d.n     = hammer_n;
                s_d.gap   = act_gap;
                s_d.per   = ref_period;
                s_d.row   = '0;
                s_d.base  = '0;
                s_d.col   = '0;
                s_d.sel_b = 1'b0;
                s_d.iter  = '0;
                s_d.total = '0;
            end
            S_FACT: if (hs) begin
                s_d.st  = S_FWR;
                s_d.col = '0;
            end
            S_FWR: if (hs) begin
                if (s_q.col == LAST_COL) s_d.st = S_FPRE;
                else                     s_d.col = s_q.col + CW'(1);
            end
            S_FPRE: if (hs) begin
                if (s_q.row != LAST_ROW) begin
                    s_d.row = s_q.row + RW'(1);
                    s_d.st  = S_FACT;
                end else begin
                    s_d.row = '0;
                    s_d.st  = (s_q.n == '0) ? S_RNEXT : S_HACT;
                end
            end
            S_HREF: if (hs) s_d.st = S_HACT;
            S_HACT: if (hs) s_d.st = S_HRD;
            S_HRD: if (hs) begin
                if (!s_q.open) begin
                    s_d.st = S_HPRE;
                end else if (s_q.iter == s_q.n - 32'd1) begin
                    s_d.iter = '0;
                    s_d.st   = S_HPRE;
                end else begin
                    s_d.iter = s_q.iter + 32'd1;
                end
            end
            S_HPRE: if (hs) begin
                if (s_q.open || s_q.iter == s_q.n - 32'd1) begin
                    s_d.iter  = '0;
                    s_d.sel_b = 1'b0;
                    if (s_q.sweep && s_q.base != LAST_ROW) begin
                        s_d.base = s_q.base + RW'(1);
                        s_d.st   = ref_pend ? S_HREF : S_HACT;
                    end else begin
                        s_d.row = '0;
                        s_d.st  = S_RNEXT;
                    end
                end else begin
                    s_d.iter  = s_q.iter + 32'd1;
                    s_d.sel_b = dual_live ? !s_q.sel_b : 1'b0;
                    s_d.st    = ref_pend ? S_HREF : S_HACT;
                end
            end
            S_RNEXT: begin
                if (!excluded) begin
                    s_d.st  = S_RACT;
                    s_d.col = '0;
                end else if (s_q.row == LAST_ROW) begin
                    s_d.st = S_DONE;
                end else begin
                    s_d.row = s_q.row + RW'(1);
                end
            end
            S_RACT: if (hs) s_d.st = S_RRD;
            S_RRD:  if (hs) s_d.st = S_RWAIT;
            S_RWAIT: if (rd_valid) begin
                s_d.rdat = rd_data;
                if (down_m != '0)    s_d.st = S_RDOWN;
                else if (up_m != '0) s_d.st = S_RUP;
                else if (s_q.col == LAST_COL) s_d.st = S_RPRE;
                else begin
                    s_d.col = s_q.col + CW'(1);
                    s_d.st  = S_RRD;
                end
            end
            S_RDOWN, S_RUP: if (ehs) begin
                if (s_q.st == S_RDOWN && up_m != '0) s_d.st = S_RUP;
                else if (s_q.col == LAST_COL)        s_d.st = S_RPRE;
                else begin
                    s_d.col = s_q.col + CW'(1);
                    s_d.st  = S_RRD;
                end
            end
            S_RPRE: if (hs) begin
                if (s_q.row == LAST_ROW) s_d.st = S_DONE;
                else begin
                    s_d.row = s_q.row + RW'(1);
                    s_d.st  = S_RNEXT;
                end
            end
            S_DONE: begin
                s_d.st   = S_IDLE;
                s_d.done = 1'b1;
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/disturb_test_seq_chk.sv
module disturb_test_seq_chk #(
    parameter int RW    = 4,
    parameter int CW    = 2,
    parameter int DW    = 8,
    parameter int TW    = 8,
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [TW-1:0]    act_gap,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_op,
    input logic [RW-1:0]    cmd_row,
    input logic [CW-1:0]    cmd_col,
    input logic             err_valid,
    input logic             err_ready,
    input logic [DW-1:0]    err_mask,
    input logic [ERR_W-1:0] err_total
);
    logic          act_hs, pre_hs, ref_hs, e_hs;
    logic          open_q;
    logic [RW-1:0] open_row_q;
    logic [TW-1:0] gap_lat_q, since_q;

    assign act_hs = cmd_valid && cmd_ready && cmd_op == 3'd1;
    assign pre_hs = cmd_valid && cmd_ready && cmd_op == 3'd4;
    assign ref_hs = cmd_valid && cmd_ready && cmd_op == 3'd5;
    assign e_hs   = err_valid && err_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q     <= 1'b0;
            open_row_q <= '0;
            gap_lat_q  <= '0;
            since_q    <= '1;
        end else begin
            if (act_hs) begin
                open_q     <= 1'b1;
                open_row_q <= cmd_row;
            end else if (pre_hs) begin
                open_q <= 1'b0;
            end
            if (start && !busy) gap_lat_q <= act_gap;
            if (act_hs)              since_q <= TW'(1);
            else if (since_q != '1)  since_q <= since_q + TW'(1);
        end
    end

    a_r1_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_row) && $stable(cmd_col));

    a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid && !err_ready |=> err_valid && $stable(err_mask));

    a_r10_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> err_mask != '0);

    a_r3_no_double_open: assert property (@(posedge clk) disable iff (!rst_n)
        act_hs |-> !open_q);

    a_r3_pre_open_row: assert property (@(posedge clk) disable iff (!rst_n)
        pre_hs |-> open_q && cmd_row == open_row_q);

    a_r7_ref_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ref_hs |-> !open_q);

    a_r6_act_gap: assert property (@(posedge clk) disable iff (!rst_n)
        act_hs |-> since_q >= gap_lat_q);

    a_r11_total_step: assert property (@(posedge clk) disable iff (!rst_n)
        e_hs && err_total != '1 |=> err_total == $past(err_total) + ERR_W'(1));

    a_r11_total_sat: assert property (@(posedge clk) disable iff (!rst_n)
        err_total == '1 && !(start && !busy) |=> err_total == '1);

    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind disturb_test_seq disturb_test_seq_chk #(
    .RW(RW), .CW(CW), .DW(DW), .TW(TW), .ERR_W(ERR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .act_gap  (act_gap),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_op   (cmd_op),
    .cmd_row  (cmd_row),
    .cmd_col  (cmd_col),
    .err_valid(err_valid),
    .err_ready(err_ready),
    .err_mask (err_mask),
    .err_total(err_total)
);

// File: tb/disturb_test_seq_tb_top.sv
`timescale 1ns/1ps
module disturb_test_seq_tb_top;
    localparam int ROWS = 16, COLS = 4, DW = 8, BW = 3, TW = 8, EW = 4;
    localparam int RW = 4, CW = 2, THR = 4;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic          mode_sweep = 0, dual_en = 0, open_row = 0;
    logic [BW-1:0] test_bank = '0;
    logic [RW-1:0] agg_a = '0, agg_b = '0;
    logic [DW-1:0] pattern = '0;
    logic [31:0]   hammer_n = '0;
    logic [TW-1:0] act_gap = '0, ref_period = '0;
    logic          cmd_valid, cmd_ready, rd_valid, err_valid, err_ready, err_dir, busy, done;
    logic [2:0]    cmd_op;
    logic [BW-1:0] cmd_bank;
    logic [RW-1:0] cmd_row, err_row;
    logic [CW-1:0] cmd_col, err_col;
    logic [DW-1:0] cmd_wdata, rd_data, err_mask;
    logic [EW-1:0] err_total;

    always #10 clk = ~clk;

    disturb_test_seq #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .BANK_W(BW), .TW(TW), .ERR_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sweep(mode_sweep), .dual_en(dual_en),
        .open_row(open_row), .test_bank(test_bank), .agg_a(agg_a), .agg_b(agg_b),
        .pattern(pattern), .hammer_n(hammer_n), .act_gap(act_gap), .ref_period(ref_period),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .err_valid(err_valid), .err_ready(err_ready), .err_row(err_row),
        .err_col(err_col), .err_mask(err_mask), .err_dir(err_dir), .err_total(err_total),
        .busy(busy), .done(done));

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- bench DRAM model ----------------
    logic [DW-1:0] mem [ROWS][COLS];
    int  act_cnt [ROWS];
    int  rd_cnt  [ROWS];
    int  rec_row [256], rec_col [256], rec_mask [256], rec_dir [256];
    int  n_rec, ref_n, ref_open, wr_n, wr_bad, bank_bad, dbl_open, min_gap, last_act, cyc;
    bit  open_f;
    logic [DW-1:0] cur_pat;
    logic [BW-1:0] cur_bank;
    bit  cpend, epend, rpend;
    int  rwait;
    logic [2:0]    c_op;
    logic [RW-1:0] c_row;
    logic [CW-1:0] c_col;
    logic [DW-1:0] c_wd, rdat_p;
    logic [BW-1:0] c_bank;
    int  e_row, e_col, e_mask, e_dir;

    task automatic model_clear();
        for (int r = 0; r < ROWS; r++) begin
            act_cnt[r] = 0;
            rd_cnt[r]  = 0;
        end
        n_rec = 0; ref_n = 0; ref_open = 0; wr_n = 0; wr_bad = 0; bank_bad = 0;
        dbl_open = 0; min_gap = 1 << 20; last_act = -1; open_f = 0;
    endtask

    task automatic flip_nb(input int x);
        if (x < ROWS - 1) mem[x+1][x % COLS] ^= DW'(1 << (x % DW));
        if (x > 0)        mem[x-1][x % COLS] ^= DW'(1 << (x % DW));
    endtask

    task automatic apply_cmd();
        if (c_bank != cur_bank) bank_bad++;
        case (c_op)
            3'd1: begin
                act_cnt[c_row]++;
                if (last_act >= 0 && cyc - last_act < min_gap) min_gap = cyc - last_act;
                last_act = cyc;
                if (open_f) dbl_open++;
                open_f = 1;
                if (act_cnt[c_row] == THR) flip_nb(int'(c_row));
            end
            3'd2: begin
                rd_cnt[c_row]++;
                rpend  = 1;
                rwait  = int'($urandom % 3);
                rdat_p = mem[c_row][c_col];
            end
            3'd3: begin
                wr_n++;
                if (c_wd != cur_pat) wr_bad++;
                mem[c_row][c_col] = c_wd;
            end
            3'd4: open_f = 0;
            3'd5: begin
                ref_n++;
                if (open_f) ref_open++;
            end
            default: ;
        endcase
    endtask

    initial begin
        cmd_ready = 0; err_ready = 0; rd_valid = 0; rd_data = '0;
        cpend = 0; epend = 0; rpend = 0; rwait = 0; cyc = 0;
        model_clear();
        forever begin
            @(negedge clk);
            cyc++;
            rd_valid = 0;
            if (cpend) apply_cmd();
            if (epend) begin
                if (n_rec < 256) begin
                    rec_row[n_rec] = e_row; rec_col[n_rec] = e_col;
                    rec_mask[n_rec] = e_mask; rec_dir[n_rec] = e_dir;
                end
                n_rec++;
            end
            if (rpend) begin
                if (rwait == 0) begin
                    rd_valid = 1; rd_data = rdat_p; rpend = 0;
                end else rwait--;
            end
            cmd_ready = ($urandom % 10) < 7;
            err_ready = ($urandom % 10) < 6;
            cpend = cmd_valid && cmd_ready;
            c_op = cmd_op; c_row = cmd_row; c_col = cmd_col; c_wd = cmd_wdata; c_bank = cmd_bank;
            epend = err_valid && err_ready;
            e_row = int'(err_row); e_col = int'(err_col); e_mask = int'(err_mask); e_dir = int'(err_dir);
        end
    end

    // ---------------- expectations ----------------
    int h_act [ROWS];
    int h_rd  [ROWS];

    task automatic expect_hammer(input bit sw, input bit du, input bit op,
                                 input int a, input int b, input int n);
        for (int r = 0; r < ROWS; r++) begin h_act[r] = 0; h_rd[r] = 0; end
        if (n == 0) return;
        for (int bs = 0; bs < ROWS; bs++) begin
            int base, part;
            if (!sw && bs > 0) break;
            base = sw ? bs : a;
            part = sw ? ((bs == ROWS - 1) ? bs - 1 : bs + 1) : b;
            if (op) begin
                h_act[base] += 1; h_rd[base] += n;
            end else if (du) begin
                h_act[base] += (n + 1) / 2; h_rd[base] += (n + 1) / 2;
                h_act[part] += n / 2;       h_rd[part] += n / 2;
            end else begin
                h_act[base] += n; h_rd[base] += n;
            end
        end
    endtask

    function automatic bit is_excl(input bit sw, input bit du, input bit op,
                                   input int a, input int b, input int r);
        return !sw && (r == a || (du && !op && r == b));
    endfunction

    task automatic run_test(input string tag, input bit sw, input bit du, input bit op,
                            input int a, input int b, input logic [DW-1:0] pat, input int n,
                            input int gap, input int per, input bit poke);
        int wd, exp_n, idx, sat;
        bit ok;
        @(negedge clk);
        model_clear();
        cur_pat = pat; cur_bank = BW'(a % 8);
        mode_sweep = sw; dual_en = du; open_row = op; agg_a = RW'(a); agg_b = RW'(b);
        pattern = pat; hammer_n = n; act_gap = TW'(gap); ref_period = TW'(per);
        test_bank = cur_bank;
        start = 1;
        @(negedge clk);
        start = 0;
        wd = 0;
        while (!done && wd < 30000) begin
            @(negedge clk);
            wd++;
            if (poke && wd % 40 == 0 && busy) begin
                // R12: a start while busy with another setup must be ignored
                pattern = ~pat; hammer_n = n + 7; agg_a = RW'(b); test_bank = ~cur_bank;
                start = 1;
                @(negedge clk);
                start = 0;
                pattern = pat; hammer_n = n; agg_a = RW'(a); test_bank = cur_bank;
            end
        end
        chk(wd < 30000, "R12", {tag, " done within watchdog"}, wd, 0);
        if (wd >= 30000) return;
        @(negedge clk);
        chk(!busy && !done, "R12", {tag, " idle after done"}, busy, 0);
        chk(bank_bad == 0, "R1", {tag, " bank on every command"}, bank_bad, 0);
        chk(wr_n == ROWS * COLS && wr_bad == 0, "R2", {tag, " fill writes"}, wr_n, ROWS * COLS);
        chk(dbl_open == 0, "R3", {tag, " activate while open"}, dbl_open, 0);
        expect_hammer(sw, du, op, a, b, n);
        for (int r = 0; r < ROWS; r++) begin
            bool_excl: begin
                bit ex = is_excl(sw, du, op, a, b, r);
                int ea = 1 + h_act[r] + (ex ? 0 : 1);
                int er = h_rd[r] + (ex ? 0 : COLS);
                chk(act_cnt[r] == ea, sw ? "R8" : (op ? "R5" : (du ? "R4" : "R3")),
                    $sformatf("%s activates row %0d", tag, r), act_cnt[r], ea);
                chk(rd_cnt[r] == er, "R9", $sformatf("%s reads row %0d", tag, r), rd_cnt[r], er);
            end
        end
        if (last_act >= 0 && min_gap != (1 << 20))
            chk(min_gap >= gap, "R6", {tag, " activate spacing"}, min_gap, gap);
        if (per == 0) chk(ref_n == 0, "R7", {tag, " no refresh when disabled"}, ref_n, 0);
        else begin
            chk(ref_open == 0, "R7", {tag, " refresh with row open"}, ref_open, 0);
            if (n >= 10 && per <= 8 && !op)
                chk(ref_n > 0, "R7", {tag, " refresh issued"}, ref_n, 1);
        end
        // R10: expected records derived from the model memory
        exp_n = 0; ok = 1;
        for (int r = 0; r < ROWS; r++) begin
            if (is_excl(sw, du, op, a, b, r)) continue;
            for (int c = 0; c < COLS; c++) begin
                logic [DW-1:0] dn, up;
                dn = pat & ~mem[r][c];
                up = ~pat & mem[r][c];
                for (int k = 0; k < 2; k++) begin
                    logic [DW-1:0] m;
                    m = (k == 0) ? dn : up;
                    if (m == '0) continue;
                    idx = exp_n;
                    if (idx >= n_rec || rec_row[idx] != r || rec_col[idx] != c ||
                        rec_mask[idx] != int'(m) || rec_dir[idx] != (k == 0 ? 1 : 0)) begin
                        if (ok) chk(0, "R10", $sformatf("%s record %0d row %0d col %0d mask", tag, idx, r, c),
                                    (idx < n_rec) ? rec_mask[idx] : -1, int'(m));
                        ok = 0;
                    end
                    exp_n++;
                end
            end
        end
        if (ok) chk(1, "R10", {tag, " records"}, 0, 0);
        chk(n_rec == exp_n, "R10", {tag, " record count"}, n_rec, exp_n);
        sat = (exp_n > 15) ? 15 : exp_n;
        chk(int'(err_total) == sat, "R11", {tag, " saturating total"}, err_total, sat);
    endtask

    initial begin
        int wdg;
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        chk(!cmd_valid && !err_valid && !busy && !done && err_total == 0, "R12",
            "reset state", {cmd_valid, err_valid, busy, done}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!cmd_valid && !busy, "R12", "idle after reset", busy, 0);

        run_test("single",      0, 0, 0, 7, 0, 8'hFF, 9,  0, 0,  0);
        run_test("dual_adj",    0, 1, 0, 5, 6, 8'hA5, 11, 0, 6,  0);
        run_test("open_row",    0, 1, 1, 3, 9, 8'h3C, 10, 0, 5,  0);
        run_test("sweep_dual",  0 == 1, 1, 0, 0, 0, 8'h0F, 5,  0, 7,  0);
        run_test("sweep_dual2", 1, 1, 0, 0, 0, 8'h0F, 5,  0, 7,  0);
        run_test("gap12",       0, 0, 0, 10, 0, 8'h55, 6, 12, 0, 0);
        run_test("n_zero",      0, 0, 0, 4, 0, 8'hC3, 0,  3, 4,  0);
        run_test("edge_row0",   0, 0, 0, 0, 0, 8'hF0, 8,  0, 0,  0);
        run_test("edge_last",   0, 1, 0, 15, 14, 8'h81, 7, 2, 3, 0);
        run_test("busy_start",  0, 0, 0, 8, 2, 8'h5A, 40, 4, 9, 1);
        for (int t = 0; t < 6; t++) begin
            int a, b;
            a = int'($urandom % ROWS);
            b = (a + 1 + int'($urandom % (ROWS - 1))) % ROWS;
            run_test($sformatf("rand%0d", t), 0, bit'($urandom % 2), bit'($urandom % 2), a, b,
                     DW'($urandom), int'($urandom % 21), int'($urandom % 9),
                     int'($urandom % 13), 0);
        end
        wdg = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #3_000_000;
        errors++;
        checks++;
        $display("FAIL R12 watchdog expired: actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule